// File: doc/BRIEF.md
# T1 Maintenance Code and Alarm Control

This block sits between a byte-wide register bus and the digital side of a T1 line interface. It has two byte registers on the bus: a control/status register and an equalizer-gain register. The block watches the received bit stream for a sustained run of ones, which is the alarm indication signal. It latches that alarm into a status bit and raises an interrupt that software can mask.

On the transmit side the block either passes the outgoing data through or replaces it with one of two repeating maintenance codes. The loop-down code has period three and the loop-up code has period five. It also drives the transmit output-enable, the receiver power-down control, the pulse-shape selection and the five-bit equalizer gain code for the analog circuits that sit outside it.

The block is clocked at the line bit rate. The strobes `rx_en` and `tx_en` qualify the bit slots in each direction. A bus write takes effect on the clock edge where `bus_we` is high. A read returns its data on `bus_rdata` one clock after the edge where `bus_re` is high.

Top module: `t1_maint_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the gain register (address 1) both read 0x00, `irq` is 0, `tx_oe` is 1, `rx_pwdn` is 0, `pulse_shape_en` is 0, `eq_gain` is 0 and the interrupt mask is clear.
- R2: The all-ones condition is declared when ONES_THRESH consecutive received ones are sampled (default 2048; a bit counts only when `rx_en` is 1). The alarm status then reads as 1 in control bit 7. A run of ONES_THRESH-1 ones followed by a zero does not set the status.
- R3: A received zero removes the all-ones condition at once and restarts the count. The status bit stays 1 for as long as the condition lasts.
- R4: A control-register read made while the condition is present does not clear the status bit. The first control-register read after the condition has ended returns bit 7 as 1 and clears the bit, so the next read returns 0.
- R5: `irq` is 1 while the status bit is 1 and the interrupt mask is 0. Writing the control register loads the mask from write-data bit 7, and a mask of 1 keeps `irq` at 0.
- R6: With control bit 5 (loop-down) set, `tx_bit` repeats 0,0,1, one bit per `tx_en` cycle.
- R7: With control bit 4 (loop-up) set, `tx_bit` repeats 0,0,0,0,1. Loop-up wins when both loop bits are set.
- R8: With control bit 3 set, `rx_pwdn` is 1, all-ones detection is held off and any present condition is removed. The transmit path keeps running.
- R9: With control bit 2 set, `tx_oe` goes to 0 one clock after the write takes effect, whatever pattern is selected. Pattern generation continues.
- R10: With neither loop bit set, `tx_bit` takes the value of `tx_data_in` one clock after each `tx_en` cycle and holds it while `tx_en` is 0.
- R11: The gain register stores write-data bits 4:0 and drives them on `eq_gain`; it reads back with bits 7:5 as 0. Control bit 6 drives `pulse_shape_en`. Control bits 1:0 always read 0.
- R12: Every control-register write restarts the loop code, so the first `tx_en` cycle after the write produces the pattern's first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control/status, 1 gain |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after the read strobe |
| rx_en | input | 1 | Receive bit slot qualifier |
| rx_bit | input | 1 | Received data bit |
| tx_en | input | 1 | Transmit bit slot qualifier |
| tx_data_in | input | 1 | Transmit data from the framer |
| tx_bit | output | 1 | Transmit data to the line driver |
| tx_oe | output | 1 | Transmit output enable (0 = high impedance) |
| irq | output | 1 | Alarm interrupt |
| rx_pwdn | output | 1 | Receiver power-down control |
| pulse_shape_en | output | 1 | Custom pulse-shape selection |
| eq_gain | output | 5 | Receive equalizer gain code |

## Verification
The bench sends ones runs one short of the threshold and exactly at it. A design with an off-by-one counter would set the alarm on the short run or miss it on the exact one. It reads the status both during the alarm and after the alarm ends, to catch a status that clears too early or that does not clear on the first read after the end. It then checks the maintenance codes bit by bit, with both loop bits set and with a rewrite in the middle of a pattern. A wrong priority, a wrong period or a phase that does not restart shows up as a single wrong bit. It also checks that power-down suppresses the alarm and that the interrupt mask, the high-impedance control and the ignored upper gain bits each leave the other outputs untouched.

// File: rtl/t1_maint_pkg.sv
package t1_maint_pkg;

  // control register field positions (decoded by software)
  localparam int unsigned CTRL_AIS_BIT  = 7;
  localparam int unsigned CTRL_PSE_BIT  = 6;
  localparam int unsigned CTRL_LDN_BIT  = 5;
  localparam int unsigned CTRL_LUP_BIT  = 4;
  localparam int unsigned CTRL_PWDN_BIT = 3;
  localparam int unsigned CTRL_HIZ_BIT  = 2;

  localparam int unsigned LOOP_DN_LEN = 3;
  localparam int unsigned LOOP_UP_LEN = 5;

  typedef enum logic [1:0] {
    LOOP_NONE = 2'd0,
    LOOP_DN   = 2'd1,
    LOOP_UP   = 2'd2
  } loop_sel_e;

  typedef struct packed {
    logic pse;
    logic ldn;
    logic lup;
    logic pwdn;
    logic hiz;
  } ctrl_fields_t;

  function automatic loop_sel_e pick_loop(input ctrl_fields_t f);
    if (f.lup)      return LOOP_UP;
    else if (f.ldn) return LOOP_DN;
    else            return LOOP_NONE;
  endfunction

endpackage

// File: rtl/t1_ctrl_regs.sv
module t1_ctrl_regs
  import t1_maint_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned GAIN_W    = 5,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned GAIN_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ais_present,
  output ctrl_fields_t      fields,
  output logic              irq_mask,
  output logic              alarm_st,
  output logic [GAIN_W-1:0] eq_gain,
  output logic              ctrl_wr,
  output logic              rd_ctrl,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_GAIN = ADDR_W'(GAIN_ADDR);

  logic gain_wr;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] gain_view;
  logic unused_wbits;

  assign ctrl_wr = we && (addr == A_CTRL);
  assign gain_wr = we && (addr == A_GAIN);
  assign rd_ctrl = re && (addr == A_CTRL);

  // only the named fields and the low gain bits are stored
  assign unused_wbits = ^{wdata[1:0], wdata[DATA_W-1:GAIN_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fields   <= '0;
      irq_mask <= 1'b0;
    end else if (ctrl_wr) begin
      irq_mask    <= wdata[CTRL_AIS_BIT];
      fields.pse  <= wdata[CTRL_PSE_BIT];
      fields.ldn  <= wdata[CTRL_LDN_BIT];
      fields.lup  <= wdata[CTRL_LUP_BIT];
      fields.pwdn <= wdata[CTRL_PWDN_BIT];
      fields.hiz  <= wdata[CTRL_HIZ_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      eq_gain <= '0;
    else if (gain_wr)
      eq_gain <= wdata[GAIN_W-1:0];
  end

  // alarm latch: set while present, cleared by a read once the condition is gone
  always_ff @(posedge clk) begin
    if (rst)
      alarm_st <= 1'b0;
    else if (ais_present)
      alarm_st <= 1'b1;
    else if (rd_ctrl)
      alarm_st <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else
      irq <= alarm_st & ~irq_mask;
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_AIS_BIT]  = alarm_st;
    ctrl_view[CTRL_PSE_BIT]  = fields.pse;
    ctrl_view[CTRL_LDN_BIT]  = fields.ldn;
    ctrl_view[CTRL_LUP_BIT]  = fields.lup;
    ctrl_view[CTRL_PWDN_BIT] = fields.pwdn;
    ctrl_view[CTRL_HIZ_BIT]  = fields.hiz;
    gain_view = '0;
    gain_view[GAIN_W-1:0] = eq_gain;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re) begin
      if (addr == A_CTRL)      rdata <= ctrl_view;
      else if (addr == A_GAIN) rdata <= gain_view;
      else                     rdata <= '0;
    end
  end

endmodule

// File: rtl/t1_ais_detect.sv
module t1_ais_detect #(
  parameter int unsigned ONES_THRESH = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic pwdn,
  input  logic rx_en,
  input  logic rx_bit,
  output logic ais_present
);

  localparam int unsigned CNT_W = (ONES_THRESH > 1) ? $clog2(ONES_THRESH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ONES_THRESH - 1);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || pwdn) begin
      run_cnt     <= '0;
      ais_present <= 1'b0;
    end else if (rx_en) begin
      if (!rx_bit) begin
        run_cnt     <= '0;
        ais_present <= 1'b0;
      end else if (run_cnt == LAST) begin
        ais_present <= 1'b1;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/t1_loop_gen.sv
module t1_loop_gen
  import t1_maint_pkg::*;
#(
  parameter int unsigned PH_W = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  input  logic      restart,
  input  loop_sel_e sel,
  input  logic      hiz,
  input  logic      tx_data_in,
  output logic      tx_bit,
  output logic      tx_oe
);

  localparam logic [PH_W-1:0] DN_LAST = PH_W'(LOOP_DN_LEN - 1);
  localparam logic [PH_W-1:0] UP_LAST = PH_W'(LOOP_UP_LEN - 1);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] last_ph;
  logic            next_bit;

  // each code is zeros ending in a single one
  always_comb begin
    case (sel)
      LOOP_DN: last_ph = DN_LAST;
      LOOP_UP: last_ph = UP_LAST;
      default: last_ph = '0;
    endcase
    if (sel == LOOP_NONE) next_bit = tx_data_in;
    else                  next_bit = (phase == last_ph);
  end

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (restart)
      phase <= '0;
    else if (tx_en) begin
      if (sel == LOOP_NONE || phase >= last_ph) phase <= '0;
      else                                      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      tx_bit <= 1'b0;
    else if (tx_en)
      tx_bit <= next_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) tx_oe <= 1'b1;
    else     tx_oe <= ~hiz;
  end

endmodule

// File: rtl/t1_maint_ctrl.sv
module t1_maint_ctrl
  import t1_maint_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned GAIN_W      = 5,
  parameter int unsigned ONES_THRESH = 2048,
  parameter int unsigned PH_W        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_en,
  input  logic              rx_bit,
  input  logic              tx_en,
  input  logic              tx_data_in,
  output logic              tx_bit,
  output logic              tx_oe,
  output logic              irq,
  output logic              rx_pwdn,
  output logic              pulse_shape_en,
  output logic [GAIN_W-1:0] eq_gain
);

  ctrl_fields_t ctrl_f;
  logic         irq_mask;
  logic         alarm_st;
  logic         ctrl_wr;
  logic         rd_ctrl;
  logic         ais_present;
  loop_sel_e    loop_sel;

  t1_ctrl_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GAIN_W(GAIN_W),
    .CTRL_ADDR(0), .GAIN_ADDR(1)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .re(bus_re),
    .wdata(bus_wdata), .rdata(bus_rdata), .ais_present(ais_present),
    .fields(ctrl_f), .irq_mask(irq_mask), .alarm_st(alarm_st),
    .eq_gain(eq_gain), .ctrl_wr(ctrl_wr), .rd_ctrl(rd_ctrl), .irq(irq)
  );

  t1_ais_detect #(.ONES_THRESH(ONES_THRESH)) u_ais (
    .clk(clk), .rst(rst), .pwdn(ctrl_f.pwdn), .rx_en(rx_en),
    .rx_bit(rx_bit), .ais_present(ais_present)
  );

  assign loop_sel = pick_loop(ctrl_f);

  t1_loop_gen #(.PH_W(PH_W)) u_loop (
    .clk(clk), .rst(rst), .tx_en(tx_en), .restart(ctrl_wr),
    .sel(loop_sel), .hiz(ctrl_f.hiz), .tx_data_in(tx_data_in),
    .tx_bit(tx_bit), .tx_oe(tx_oe)
  );

  assign rx_pwdn        = ctrl_f.pwdn;
  assign pulse_shape_en = ctrl_f.pse;

endmodule

// File: rtl/t1_maint_chk.sv
module t1_maint_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic rx_bit,
  input logic ais_present,
  input logic alarm_st,
  input logic rd_ctrl,
  input logic irq_mask,
  input logic irq,
  input logic hiz,
  input logic pwdn,
  input logic tx_oe
);

  AST_PRESENT_FROM_ONES: assert property (@(posedge clk) disable iff (rst)
    $rose(ais_present) |-> ($past(rx_en) && $past(rx_bit))); // R2

  AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ais_present |=> alarm_st); // R3

  AST_CLEAR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_st) |-> ($past(rd_ctrl) && !$past(ais_present))); // R4

  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (alarm_st && !irq_mask) |=> irq); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq_mask && $past(irq_mask)) |-> !irq); // R5

  AST_PWDN_NO_ALARM: assert property (@(posedge clk) disable iff (rst)
    pwdn |=> !ais_present); // R8

  AST_HIZ_OE: assert property (@(posedge clk) disable iff (rst)
    hiz |=> !tx_oe); // R9

endmodule

bind t1_maint_ctrl t1_maint_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit),
  .ais_present(ais_present), .alarm_st(alarm_st), .rd_ctrl(rd_ctrl),
  .irq_mask(irq_mask), .irq(irq), .hiz(ctrl_f.hiz), .pwdn(ctrl_f.pwdn),
  .tx_oe(tx_oe)
);

// File: tb/tb_t1_maint_ctrl.sv
`timescale 1ns/1ps
module tb_t1_maint_ctrl;

  localparam int THRESH = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_en = 1'b1;
  logic       rx_bit = 1'b0;
  logic       tx_en = 1'b1;
  logic       tx_data_in = 1'b0;
  logic       tx_bit, tx_oe, irq, rx_pwdn, pulse_shape_en;
  logic [4:0] eq_gain;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  t1_maint_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_en(rx_en), .rx_bit(rx_bit), .tx_en(tx_en), .tx_data_in(tx_data_in),
    .tx_bit(tx_bit), .tx_oe(tx_oe), .irq(irq), .rx_pwdn(rx_pwdn),
    .pulse_shape_en(pulse_shape_en), .eq_gain(eq_gain)
  );

  // sel: 0 none, 1 loop-down (0,0,1), 2 loop-up (0,0,0,0,1)
  function automatic logic exp_pat(int sel, int k);
    if (sel == 2) return (k % 5) == 4;
    return (k % 3) == 2;
  endfunction

  function automatic logic [7:0] exp_gain_rd(logic [7:0] w);
    return {3'b000, w[4:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive n ones, each sampled by one rising edge; leave rx_bit at 'tail'
  task automatic ones(int n, logic tail);
    @(negedge clk);
    rx_bit = 1'b1;
    repeat (n) @(negedge clk);
    rx_bit = tail;
  endtask

  // call right after wr(): checks n bits of the selected code from its first bit
  task automatic chk_pat(string req, int sel, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(req, tx_bit, exp_pat(sel, k));
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int seed;
    seed = 32'h1d5e;
    void'($urandom(seed));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 tx_oe", tx_oe, 1);
    check("R1 rx_pwdn", rx_pwdn, 0);
    check("R1 pse", pulse_shape_en, 0);
    check("R1 eq_gain", eq_gain, 0);
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 gain", d, 8'h00);

    // R10 pass-through with random data
    for (int i = 0; i < 40; i++) begin
      logic b;
      b = 1'($urandom);
      tx_data_in = b;
      @(negedge clk);
      check("R10 passthru", tx_bit, b);
    end
    // R10 hold while tx_en low
    tx_data_in = 1'b1; @(negedge clk);
    tx_en = 1'b0; tx_data_in = 1'b0;
    idle(3);
    check("R10 hold", tx_bit, 1);
    tx_en = 1'b1;

    // R11 gain register with random data, upper bits ignored
    for (int i = 0; i < 10; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      wr(2'd1, w);
      check("R11 eq_gain", eq_gain, w[4:0]);
      rd(2'd1, d); check("R11 gain readback", d, exp_gain_rd(w));
    end
    check("R11 ctrl untouched", pulse_shape_en, 0);
    wr(2'd0, 8'h43);   // pse plus reserved bits
    check("R11 pse", pulse_shape_en, 1);
    rd(2'd0, d); check("R11 reserved read 0", d, 8'h40);
    wr(2'd0, 8'h00);

    // R2 one short of threshold: no alarm
    ones(THRESH - 1, 1'b0);
    idle(3);
    rd(2'd0, d); check("R2 short run", d, 8'h00);
    check("R2 short irq", irq, 0);

    // R2 exact threshold, R3 persists, R4 read while present keeps it
    ones(THRESH, 1'b1);
    idle(3);
    check("R5 irq set", irq, 1);
    rd(2'd0, d); check("R2 status set", d, 8'h80);
    rd(2'd0, d); check("R4 read during alarm", d, 8'h80);
    // R3 zero removes condition
    rx_bit = 1'b0;
    idle(3);
    check("R3 irq held after end", irq, 1);
    rd(2'd0, d); check("R4 clearing read", d, 8'h80);
    rd(2'd0, d); check("R4 cleared", d, 8'h00);
    idle(2);
    check("R5 irq cleared", irq, 0);

    // R5 mask
    wr(2'd0, 8'h80);
    ones(THRESH + 10, 1'b0);
    idle(3);
    check("R5 masked irq", irq, 0);
    rd(2'd0, d); check("R5 masked status", d, 8'h80);
    rd(2'd0, d); check("R5 masked cleared", d, 8'h00);
    wr(2'd0, 8'h00);

    // R8 power-down suppresses detection, transmitter still runs
    wr(2'd0, 8'h08);
    check("R8 rx_pwdn", rx_pwdn, 1);
    ones(THRESH + 100, 1'b0);
    idle(3);
    check("R8 no irq", irq, 0);
    rd(2'd0, d); check("R8 no status", d, 8'h08);
    wr(2'd0, 8'h28);
    chk_pat("R8 tx in pwdn", 1, 9);
    wr(2'd0, 8'h00);
    check("R8 rx_pwdn off", rx_pwdn, 0);

    // R6 loop-down
    wr(2'd0, 8'h20);
    chk_pat("R6 loop-down", 1, 12);
    // R12 restart mid pattern
    idle(1);
    wr(2'd0, 8'h20);
    chk_pat("R12 restart dn", 1, 6);

    // R7 loop-up, and priority with both set
    wr(2'd0, 8'h10);
    chk_pat("R7 loop-up", 2, 15);
    wr(2'd0, 8'h30);
    chk_pat("R7 priority", 2, 10);
    idle(2);
    wr(2'd0, 8'h10);
    chk_pat("R12 restart up", 2, 5);

    // R9 high impedance with pattern still produced
    wr(2'd0, 8'h14);
    chk_pat("R9 pattern under hiz", 2, 10);
    check("R9 tx_oe low", tx_oe, 0);
    wr(2'd0, 8'h00);
    idle(1);
    check("R9 tx_oe back", tx_oe, 1);

    // random loop selections
    for (int i = 0; i < 8; i++) begin
      int s;
      s = 1 + int'($urandom % 2);
      wr(2'd0, (s == 2) ? 8'h10 : 8'h20);
      chk_pat((s == 2) ? "R7 random" : "R6 random", s, 10);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule